// File: doc/BRIEF.md
# Low-Supply Detector Status and Interrupt Registers

This block sits between an analog low-supply comparator and a 16-bit register bus. It brings the comparator's asynchronous "supply low" result and its measurement-valid strobe into the clock domain through flop synchronisers. The synchronised result is shown as a live status bit. When a new measurement arrives with the supply below threshold and the detector switched on, a sticky interrupt flag is set.

Software reads the flag and the live result from one register and writes 1 to clear the flag. An enable register gates the flag onto the interrupt request. Clearing the flag while the detector is switched on also sends a one-cycle reinitialise pulse back to the detector.

A 4-bit action-select input picks between interrupt and reset behaviour. With the reset code selected, a low supply raises a level reset request, and the interrupt request is held low whatever the flag and the enable hold.

Top module: `supmon_top`

## Requirements
- R1: A read at byte offset 0 returns the synchronised comparator result at bit 8 and the interrupt flag at bit 0. Every other bit reads 0.
- R2: The comparator input passes through two flops. A change on `cmp_low` shows in the status bit after the second rising clock edge, not after the first.
- R3: After synchronous reset, the flag and the enable bit are 0, and `irq`, `rst_req` and `reinit_pulse` are low.
- R4: The flag sets on the third clock edge after `meas_valid` rises, provided the synchronised comparator result is 1 and `det_on` is 1.
- R5: The flag does not set when `det_on` is 0 or the synchronised comparator result is 0. A `meas_valid` that stays high does not set it again: only a 0-to-1 transition counts.
- R6: Writing a word with bit 0 = 1 to offset 0 clears the flag on that clock edge. Writing bit 0 = 0 leaves the flag unchanged.
- R7: When a flag set and a write-1 clear fall on the same clock edge, the flag ends up 1.
- R8: A write-1 to the flag bit while `det_on` is 1 makes `reinit_pulse` high for the cycle after that write only. With `det_on` at 0, no pulse is produced.
- R9: Offset 2 holds the interrupt enable at bit 0, which can be both written and read. Bits 15..1 of that register read 0 and ignore writes.
- R10: When `act_sel` is not 4'hA, `irq` equals the flag AND the enable bit.
- R11: When `act_sel` equals 4'hA, `irq` stays low. `rst_req` then follows the synchronised comparator result as a level.
- R12: Reads at any offset other than 0 or 2 return 0. Writes to such offsets change neither the flag nor the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| cmp_low | input | 1 | Asynchronous comparator result, 1 = supply below threshold |
| meas_valid | input | 1 | Asynchronous strobe marking a fresh comparator result |
| det_on | input | 1 | Detector switched on |
| act_sel | input | 4 | Action select; 4'hA selects reset action |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | Reset request level |
| reinit_pulse | output | 1 | One-cycle restart pulse to the detector |

## Verification
The measurement strobe is applied in three conditions: with the detector off, with the comparator reading high supply, and with both conditions met. Only the last may set the flag, which separates the qualifying terms from each other. A strobe held high across a clear shows that set is edge-triggered rather than level-triggered. A clear write timed onto the set edge shows that set has priority. The same clear is repeated with the detector on and off to show what triggers the reinitialise pulse. The action select is swapped while the flag and the enable are both 1 and the comparator is toggled, which separates interrupt masking from reset-level tracking.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
    localparam int DATA_W    = 16;
    localparam int OFS_STAT  = 0;
    localparam int OFS_EN    = 2;
    localparam logic [3:0] RST_CODE = 4'hA;

    typedef struct packed {
        logic [6:0] rsv_hi;
        logic       det;
        logic [6:0] rsv_lo;
        logic       flag;
    } stat_word_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_EN   = 2'd2
    } reg_sel_t;

    function automatic stat_word_t pack_status(input logic det, input logic flag);
        stat_word_t w;
        w        = '0;
        w.det    = det;
        w.flag   = flag;
        return w;
    endfunction
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/supmon_event.sv
module supmon_event (
    input  logic clk,
    input  logic rst,
    input  logic valid_s,
    input  logic cmp_s,
    input  logic det_on,
    input  logic clr_wr,
    output logic flag,
    output logic reinit
);
    logic valid_d;
    logic set_evt;

    assign set_evt = valid_s && !valid_d && cmp_s && det_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_d <= 1'b0;
            flag    <= 1'b0;
            reinit  <= 1'b0;
        end else begin
            valid_d <= valid_s;
            reinit  <= clr_wr && det_on;
            if (set_evt)     flag <= 1'b1;
            else if (clr_wr) flag <= 1'b0;
        end
    end

    // R4: a qualified set always leaves the flag high
    a_r4_set_takes: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag);

    // R6: an uncontested clear always leaves the flag low
    a_r6_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !set_evt) |=> !flag);
endmodule

// File: rtl/supmon_bus.sv
module supmon_bus
    import supmon_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              wbit0,
    input  logic              det_s,
    input  logic              flag,
    output logic              clr_wr,
    output logic              en,
    output logic [DATA_W-1:0] rdata
);
    reg_sel_t sel;

    always_comb begin
        if (addr == ADDR_W'(OFS_STAT))    sel = SEL_STAT;
        else if (addr == ADDR_W'(OFS_EN)) sel = SEL_EN;
        else                              sel = SEL_NONE;
    end

    assign clr_wr = wr && (sel == SEL_STAT) && wbit0;

    always_ff @(posedge clk) begin
        if (rst)                        en <= 1'b0;
        else if (wr && sel == SEL_EN)   en <= wbit0;
    end

    always_comb begin
        case (sel)
            SEL_STAT: rdata = pack_status(det_s, flag);
            SEL_EN:   rdata = {{(DATA_W-1){1'b0}}, en};
            default:  rdata = '0;
        endcase
    end

    // R9 / R12: the enable bit only moves on a write to its own offset
    a_r9_en_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == ADDR_W'(OFS_EN)) |=> $stable(en));
endmodule

// File: rtl/supmon_top.sv
module supmon_top
    import supmon_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              cmp_low,
    input  logic              meas_valid,
    input  logic              det_on,
    input  logic [3:0]        act_sel,
    output logic              irq,
    output logic              rst_req,
    output logic              reinit_pulse
);
    logic [1:0] sync_q;
    logic       cmp_s;
    logic       valid_s;
    logic       flag;
    logic       en;
    logic       clr_wr;
    logic       rst_mode;
    logic       unused_wdata;

    assign unused_wdata = ^bus_wdata[15:1];

    supmon_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({meas_valid, cmp_low}),
        .q   (sync_q)
    );
    assign cmp_s   = sync_q[0];
    assign valid_s = sync_q[1];

    supmon_event event_i (
        .clk     (clk),
        .rst     (rst),
        .valid_s (valid_s),
        .cmp_s   (cmp_s),
        .det_on  (det_on),
        .clr_wr  (clr_wr),
        .flag    (flag),
        .reinit  (reinit_pulse)
    );

    supmon_bus #(.ADDR_W(ADDR_W)) bus_i (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wbit0  (bus_wdata[0]),
        .det_s  (cmp_s),
        .flag   (flag),
        .clr_wr (clr_wr),
        .en     (en),
        .rdata  (bus_rdata)
    );

    assign rst_mode = (act_sel == RST_CODE);
    assign irq      = flag && en && !rst_mode;
    assign rst_req  = rst_mode && cmp_s;

    // R11: reset action keeps the interrupt request quiet
    a_r11_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (act_sel == RST_CODE) |-> !irq);

    // R8: every restart pulse comes from a flag clear made while the detector was on
    a_r8_reinit_src: assert property (@(posedge clk) disable iff (rst)
        reinit_pulse |-> $past(bus_wr && bus_addr == ADDR_W'(OFS_STAT)
                               && bus_wdata[0] && det_on));
endmodule

// File: tb/supmon_top_tb.sv
module supmon_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cmp_low = 1'b0;
    logic        meas_valid = 1'b0;
    logic        det_on = 1'b0;
    logic [3:0]  act_sel = 4'h0;
    logic        irq, rst_req, reinit_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supmon_top dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_low(cmp_low),
        .meas_valid(meas_valid), .det_on(det_on), .act_sel(act_sel),
        .irq(irq), .rst_req(rst_req), .reinit_pulse(reinit_pulse)
    );

    // Behavioural reference: delay queues for the synchronised inputs
    bit cq[$];
    bit vq[$];
    bit m_vprev, m_flag, m_en, m_reinit;

    initial begin
        cq = '{1'b0, 1'b0};
        vq = '{1'b0, 1'b0};
        m_vprev = 0; m_flag = 0; m_en = 0; m_reinit = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            cq = '{1'b0, 1'b0};
            vq = '{1'b0, 1'b0};
            m_vprev = 0; m_flag = 0; m_en = 0; m_reinit = 0;
        end else begin
            bit csync, vsync, setev, clrev;
            csync = cq[0];
            vsync = vq[0];
            setev = vsync && !m_vprev && csync && det_on;
            clrev = bus_wr && bus_addr == 4'd0 && bus_wdata[0];
            m_reinit = clrev && det_on;
            if (setev) m_flag = 1;
            else if (clrev) m_flag = 0;
            if (bus_wr && bus_addr == 4'd2) m_en = bus_wdata[0];
            m_vprev = vsync;
            void'(cq.pop_front()); cq.push_back(cmp_low);
            void'(vq.pop_front()); vq.push_back(meas_valid);
        end
    end

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (live && !done) begin
            logic [15:0] exp_rd;
            bit rmode;
            rmode = (act_sel == 4'hA);
            case (bus_addr)
                4'd0:    exp_rd = {7'd0, cq[0], 7'd0, m_flag};
                4'd2:    exp_rd = {15'd0, m_en};
                default: exp_rd = 16'd0;
            endcase
            chk("MODEL R1/R9/R12 rdata", bus_rdata, exp_rd);
            chk("MODEL R10/R11 irq", {15'd0, irq}, {15'd0, m_flag && m_en && !rmode});
            chk("MODEL R11 rst_req", {15'd0, rst_req}, {15'd0, rmode && cq[0]});
            chk("MODEL R8 reinit", {15'd0, reinit_pulse}, {15'd0, m_reinit});
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic rd(logic [3:0] a, logic [15:0] exp, string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick(1);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        live = 1'b1;
        // R3 reset state
        rd(4'd0, 16'h0000, "R3 status after reset");
        rd(4'd2, 16'h0000, "R3 enable after reset");
        chk("R3 irq low", {15'd0, irq}, 16'd0);
        chk("R3 rst_req low", {15'd0, rst_req}, 16'd0);
        chk("R3 reinit low", {15'd0, reinit_pulse}, 16'd0);

        // R2 two-edge synchroniser latency
        cmp_low = 1'b1;
        tick(1);
        rd(4'd0, 16'h0000, "R2 status after one edge");
        tick(1);
        rd(4'd0, 16'h0100, "R1 R2 status bit 8 after two edges");

        // R5 detector off: no set
        meas_valid = 1'b1; tick(4);
        rd(4'd0, 16'h0100, "R5 no set while det_on=0");
        meas_valid = 1'b0; tick(3);

        // R4 set on third edge
        det_on = 1'b1; meas_valid = 1'b1;
        tick(2);
        rd(4'd0, 16'h0100, "R4 flag not yet set after two edges");
        tick(1);
        rd(4'd0, 16'h0101, "R4 flag set on third edge");
        chk("R10 irq low while enable 0", {15'd0, irq}, 16'd0);

        // R6/R8 clear while strobe still high
        wr(4'd0, 16'h0001);
        rd(4'd0, 16'h0100, "R6 write-1 clears flag");
        chk("R8 reinit pulse after clear", {15'd0, reinit_pulse}, 16'd1);
        tick(1);
        chk("R8 reinit lasts one cycle", {15'd0, reinit_pulse}, 16'd0);
        tick(3);
        rd(4'd0, 16'h0100, "R5 held strobe does not set again");

        // R6 write-0 has no effect
        meas_valid = 1'b0; tick(3);
        meas_valid = 1'b1; tick(3);
        rd(4'd0, 16'h0101, "R4 flag set again");
        wr(4'd0, 16'hFFFE);
        rd(4'd0, 16'h0101, "R6 write-0 keeps flag");
        chk("R8 no pulse on write-0", {15'd0, reinit_pulse}, 16'd0);

        // R9/R10 enable register
        wr(4'd2, 16'hFFFF);
        rd(4'd2, 16'h0001, "R9 enable reads only bit 0");
        chk("R10 irq = flag & enable", {15'd0, irq}, 16'd1);
        wr(4'd2, 16'hFFFE);
        rd(4'd2, 16'h0000, "R9 enable cleared");
        chk("R10 irq low with enable 0", {15'd0, irq}, 16'd0);
        wr(4'd2, 16'h0001);

        // R11 reset action
        act_sel = 4'hA; #1;
        chk("R11 irq suppressed", {15'd0, irq}, 16'd0);
        chk("R11 rst_req high", {15'd0, rst_req}, 16'd1);
        cmp_low = 1'b0; tick(2);
        chk("R11 rst_req follows comparator low", {15'd0, rst_req}, 16'd0);
        cmp_low = 1'b1; tick(2);
        chk("R11 rst_req back high", {15'd0, rst_req}, 16'd1);
        act_sel = 4'h5; #1;
        chk("R10 irq returns outside reset code", {15'd0, irq}, 16'd1);
        chk("R11 rst_req low outside reset code", {15'd0, rst_req}, 16'd0);

        // R12 unmapped offsets
        rd(4'd4, 16'h0000, "R12 offset 4 reads 0");
        rd(4'd1, 16'h0000, "R12 offset 1 reads 0");
        wr(4'd6, 16'hFFFF);
        wr(4'd4, 16'h0001);
        rd(4'd0, 16'h0101, "R12 unmapped writes leave flag");
        rd(4'd2, 16'h0001, "R12 unmapped writes leave enable");

        // R7 set wins over a same-edge clear
        wr(4'd0, 16'h0001);
        meas_valid = 1'b0; tick(3);
        meas_valid = 1'b1; tick(2);
        wr(4'd0, 16'h0001);
        rd(4'd0, 16'h0101, "R7 set beats clear");

        // R8 no pulse with detector off
        det_on = 1'b0;
        wr(4'd0, 16'h0001);
        rd(4'd0, 16'h0100, "R6 clear with detector off");
        chk("R8 no pulse when det_on=0", {15'd0, reinit_pulse}, 16'd0);
        det_on = 1'b1;

        // R5 comparator high-supply: no set
        cmp_low = 1'b0; tick(2);
        meas_valid = 1'b0; tick(3);
        meas_valid = 1'b1; tick(4);
        rd(4'd0, 16'h0000, "R5 no set with comparator 0");

        tick(2);
        finish_run();
    end
endmodule